// File: doc/BRIEF.md
# Nine-Valued Bus Line with Inverting Tri-State Drivers

This block models one shared bus line in a nine-valued logic system, with no clock and no state. A parameterised number of inverting tri-state drivers (three by default) and a weak pull resistor are attached to the line. Each driver takes a nine-valued data code and a nine-valued active-low enable code.

When a driver is enabled, its output is the inverted data. When the enable is high, the driver's output is high impedance. An enable that is neither a clean low nor a clean high gives an unknown output. The block merges the pull value and every driver output into one resolved bus value. It also raises a short flag when that value is the strong unknown. Each driver's own output is also brought out, so the stages can be observed one by one.

All values use a 4-bit code: U=0, X=1, strong 0=2, strong 1=3, Z=4, W=5, L=6, H=7, D=8. Codes 9 to 15 are not legal values and are treated as undefined.

Top module: `bus9_line`

## Requirements
- R1: Every input and output value uses the 4-bit code U=0, X=1, 0=2, 1=3, Z=4, W=5, L=6, H=7, D=8. A driver whose enable code is 1 (3) or H (7) outputs Z (4).
- R2: A driver whose enable code is 0 (2) or L (6) outputs the inverse of its data. Data 0 (2) or L (6) gives 1 (3), data 1 (3) or H (7) gives 0 (2), data U (0) gives U (0), and any other data code gives X (1).
- R3: A driver whose enable code is any value other than 0, 1, L or H outputs X (1), whatever its data is.
- R4: When no driver is enabled, the bus reads the pull value H (7) and the short flag is low.
- R5: When exactly one driver is enabled and its data is a clean 0, 1, L or H, the bus equals that driver's inverted data.
- R6: Enabled drivers that agree leave the bus at their common value. A strong 0 and a strong 1 on the line together give X (1).
- R7: A U (0) from any driver makes the bus U (0), and the short flag is then low.
- R8: The short flag is high exactly when the resolved bus value is X (1).
- R9: Swapping the data and enable codes between any two drivers does not change the bus value.
- R10: Data and enable codes 9 to 15 are undefined. On an enable they give an X output. On the data of an enabled driver they give an X output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| drv_data | input | 12 | Data code of each driver; driver i uses bits [4i+3:4i] |
| drv_en_n | input | 12 | Active-low enable code of each driver, packed in the same way |
| drv_out | output | 12 | Output code of each driver, packed in the same way |
| bus_val | output | 4 | Resolved code of the bus line |
| short_flag | output | 1 | High when the resolved bus value is X |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies on any path. The bench therefore applies each new vector just after a rising edge of its pacing clock and compares the driver outputs, the bus value and the short flag at the following falling edge, once the logic has settled. The expected values come from a behavioural model that ranks the contributions by strength. This model is checked on the per-driver sweep, on the swap vectors, on the directed corners and on a long run of random code combinations.

// File: rtl/bus9_pkg.sv
package bus9_pkg;

  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] V_U = 4'd0;
  localparam logic [CODE_W-1:0] V_X = 4'd1;
  localparam logic [CODE_W-1:0] V_0 = 4'd2;
  localparam logic [CODE_W-1:0] V_1 = 4'd3;
  localparam logic [CODE_W-1:0] V_Z = 4'd4;
  localparam logic [CODE_W-1:0] V_W = 4'd5;
  localparam logic [CODE_W-1:0] V_L = 4'd6;
  localparam logic [CODE_W-1:0] V_H = 4'd7;
  localparam logic [CODE_W-1:0] V_D = 4'd8;

  typedef enum logic [1:0] {
    EN_ON    = 2'd0,
    EN_OFF   = 2'd1,
    EN_UNDEF = 2'd2
  } en_state_e;

  function automatic logic is_strong_lvl(input logic [CODE_W-1:0] v);
    return (v == V_0) || (v == V_1);
  endfunction

  function automatic logic is_weak_lvl(input logic [CODE_W-1:0] v);
    return (v == V_W) || (v == V_L) || (v == V_H);
  endfunction

  function automatic logic is_hard_unknown(input logic [CODE_W-1:0] v);
    return (v == V_X) || (v == V_D) || (v > V_D);
  endfunction

endpackage

// File: rtl/bus9_inv_drv.sv
module bus9_inv_drv
  import bus9_pkg::*;
(
  input  logic [CODE_W-1:0] data_i,
  input  logic [CODE_W-1:0] en_n_i,
  output logic [CODE_W-1:0] out_o
);

  en_state_e            en_st;
  logic [CODE_W-1:0]    inv_val;

  always_comb begin
    unique case (en_n_i)
      V_0, V_L: en_st = EN_ON;
      V_1, V_H: en_st = EN_OFF;
      default:  en_st = EN_UNDEF;
    endcase
  end

  always_comb begin
    unique case (data_i)
      V_0, V_L: inv_val = V_1;
      V_1, V_H: inv_val = V_0;
      V_U:      inv_val = V_U;
      default:  inv_val = V_X;
    endcase
  end

  always_comb begin
    unique case (en_st)
      EN_ON:   out_o = inv_val;
      EN_OFF:  out_o = V_Z;
      default: out_o = V_X;
    endcase
  end

  // R2: an enabled driver is always a strong or unknown source, never weak or floating
  always_comb begin
    if ((en_n_i == V_0) || (en_n_i == V_L)) begin
      a_r2_enabled_not_weak: assert (!is_weak_lvl(out_o) && (out_o != V_Z))
        else $error("R2: enabled driver produced weak/floating code %0d", out_o);
    end
  end

endmodule

// File: rtl/bus9_res_pair.sv
module bus9_res_pair
  import bus9_pkg::*;
(
  input  logic [CODE_W-1:0] a_i,
  input  logic [CODE_W-1:0] b_i,
  output logic [CODE_W-1:0] y_o
);

  always_comb begin
    if ((a_i == V_U) || (b_i == V_U)) begin
      y_o = V_U;
    end else if (is_hard_unknown(a_i) || is_hard_unknown(b_i)) begin
      y_o = V_X;
    end else if (a_i == b_i) begin
      y_o = a_i;
    end else if (a_i == V_Z) begin
      y_o = b_i;
    end else if (b_i == V_Z) begin
      y_o = a_i;
    end else if (is_strong_lvl(a_i)) begin
      y_o = is_strong_lvl(b_i) ? V_X : a_i;
    end else if (is_strong_lvl(b_i)) begin
      y_o = b_i;
    end else begin
      y_o = V_W;
    end
  end

  // R7: an undefined-initial contribution always survives the merge
  always_comb begin
    if ((a_i == V_U) || (b_i == V_U)) begin
      a_r7_pair_keeps_u: assert (y_o == V_U)
        else $error("R7: pair merge lost U, got %0d", y_o);
    end
  end

endmodule

// File: rtl/bus9_line.sv
module bus9_line
  import bus9_pkg::*;
#(
  parameter int unsigned         NUM_DRV   = 3,
  parameter logic [CODE_W-1:0]   PULL_CODE = V_H
)(
  input  logic [NUM_DRV*CODE_W-1:0] drv_data,
  input  logic [NUM_DRV*CODE_W-1:0] drv_en_n,
  output logic [NUM_DRV*CODE_W-1:0] drv_out,
  output logic [CODE_W-1:0]         bus_val,
  output logic                      short_flag
);

  localparam int unsigned N_STAGE = NUM_DRV + 1;

  logic [CODE_W-1:0] stage [N_STAGE];

  assign stage[0] = PULL_CODE;

  for (genvar gi = 0; gi < NUM_DRV; gi++) begin : g_drv
    logic [CODE_W-1:0] d_out;

    bus9_inv_drv u_drv (
      .data_i (drv_data[gi*CODE_W +: CODE_W]),
      .en_n_i (drv_en_n[gi*CODE_W +: CODE_W]),
      .out_o  (d_out)
    );

    bus9_res_pair u_merge (
      .a_i (stage[gi]),
      .b_i (d_out),
      .y_o (stage[gi+1])
    );

    assign drv_out[gi*CODE_W +: CODE_W] = d_out;
  end

  assign bus_val    = stage[NUM_DRV];
  assign short_flag = (stage[NUM_DRV] == V_X);

  // Observation of driver outputs for the line-level checks
  int unsigned n_float;
  logic        seen_lo;
  logic        seen_hi;
  logic        seen_u;

  always_comb begin
    n_float = 0;
    seen_lo = 1'b0;
    seen_hi = 1'b0;
    seen_u  = 1'b0;
    for (int k = 0; k < NUM_DRV; k++) begin
      if (drv_out[k*CODE_W +: CODE_W] == V_Z) n_float++;
      if (drv_out[k*CODE_W +: CODE_W] == V_0) seen_lo = 1'b1;
      if (drv_out[k*CODE_W +: CODE_W] == V_1) seen_hi = 1'b1;
      if (drv_out[k*CODE_W +: CODE_W] == V_U) seen_u  = 1'b1;
    end
  end

  always_comb begin
    if (n_float == NUM_DRV) begin
      a_r4_idle_reads_pull: assert (bus_val == PULL_CODE)
        else $error("R4: idle bus read %0d", bus_val);
    end
    if (seen_lo && seen_hi && !seen_u) begin
      a_r6_conflict_shorts: assert (short_flag)
        else $error("R6: opposing strong drivers without short flag");
    end
    if (seen_u) begin
      a_r7_u_dominates: assert ((bus_val == V_U) && !short_flag)
        else $error("R7: U driver but bus %0d", bus_val);
    end
    if (short_flag) begin
      a_r8_short_has_no_u: assert (!seen_u && (n_float < NUM_DRV || PULL_CODE == V_X))
        else $error("R8: short flag with U present or idle line");
    end
  end

endmodule

// File: tb/bus9_line_bench.sv
module bus9_line_bench;

  localparam int ND = 3;

  logic clk;
  logic rst_n;
  logic [ND*4-1:0] drv_data;
  logic [ND*4-1:0] drv_en_n;
  logic [ND*4-1:0] drv_out;
  logic [3:0]      bus_val;
  logic            short_flag;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  bus9_line u_bus9_line (
    .drv_data   (drv_data),
    .drv_en_n   (drv_en_n),
    .drv_out    (drv_out),
    .bus_val    (bus_val),
    .short_flag (short_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  // ---------------- behavioural reference ----------------
  function automatic int m_drv(input int a, input int s);
    if (s == 2 || s == 6) begin
      if (a == 2 || a == 6) return 3;
      if (a == 3 || a == 7) return 2;
      if (a == 0) return 0;
      return 1;
    end
    if (s == 3 || s == 7) return 4;
    return 1;
  endfunction

  function automatic int m_res(input int v0, input int v1, input int v2, input int v3);
    int v[4];
    int n_u = 0, n_x = 0, n0 = 0, n1 = 0, nw = 0, nl = 0, nh = 0;
    v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
    foreach (v[i]) begin
      case (v[i])
        0: n_u++;
        2: n0++;
        3: n1++;
        4: ;
        5: nw++;
        6: nl++;
        7: nh++;
        default: n_x++;
      endcase
    end
    if (n_u > 0) return 0;
    if (n_x > 0) return 1;
    if (n0 > 0 && n1 > 0) return 1;
    if (n0 > 0) return 2;
    if (n1 > 0) return 3;
    if (nw > 0 || (nl > 0 && nh > 0)) return 5;
    if (nl > 0) return 6;
    if (nh > 0) return 7;
    return 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (data=%h en=%h)", req, act, exp, drv_data, drv_en_n);
    end
  endtask

  task automatic apply(input logic [ND*4-1:0] d, input logic [ND*4-1:0] e);
    @(posedge clk);
    #1;
    drv_data = d;
    drv_en_n = e;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    int o[ND];
    int exp_bus;
    for (int k = 0; k < ND; k++) begin
      o[k] = m_drv(int'(drv_data[k*4 +: 4]), int'(drv_en_n[k*4 +: 4]));
      chk(req, int'(drv_out[k*4 +: 4]), o[k]);
    end
    exp_bus = m_res(7, o[0], o[1], o[2]);
    chk(req, int'(bus_val), exp_bus);
    chk("R8", int'(short_flag), (exp_bus == 1) ? 1 : 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cycles > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [3:0] swap_bus;
    rst_n    = 1'b0;
    drv_data = '0;
    drv_en_n = {4'd3, 4'd3, 4'd3};
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: every driver off, bus reads pull H (R4)
    @(negedge clk);
    chk("R4", int'(bus_val), 7);
    chk("R4", int'(short_flag), 0);
    chk("R1", int'(drv_out[3:0]), 4);

    // Per-driver sweep over all 16x16 codes, others disabled (R1 R2 R3 R5 R10)
    for (int k = 0; k < ND; k++) begin
      for (int s = 0; s < 16; s++) begin
        for (int a = 0; a < 16; a++) begin
          logic [ND*4-1:0] d, e;
          d = '0;
          e = {4'd7, 4'd7, 4'd7};
          d[k*4 +: 4] = 4'(a);
          e[k*4 +: 4] = 4'(s);
          apply(d, e);
          check_all("R2");
        end
      end
    end

    // Directed corners
    apply({4'd3, 4'd2, 4'd6}, {4'd7, 4'd7, 4'd3});   // R1: enable 1 and H both off
    chk("R1", int'(drv_out[3:0]), 4);
    chk("R1", int'(drv_out[11:8]), 4);
    apply({4'd0, 4'd0, 4'd3}, {4'd3, 4'd3, 4'd2});   // R5: single driver, data 1 -> bus 0
    chk("R5", int'(bus_val), 2);
    apply({4'd0, 4'd6, 4'd2}, {4'd3, 4'd6, 4'd2});   // R6: two agree on 1
    chk("R6", int'(bus_val), 3);
    chk("R6", int'(short_flag), 0);
    apply({4'd0, 4'd3, 4'd2}, {4'd3, 4'd2, 4'd6});   // R6: conflict -> X
    chk("R6", int'(bus_val), 1);
    chk("R8", int'(short_flag), 1);
    apply({4'd0, 4'd3, 4'd2}, {4'd2, 4'd2, 4'd6});   // R7: U plus conflict -> U
    chk("R7", int'(bus_val), 0);
    chk("R7", int'(short_flag), 0);
    apply({4'd0, 4'd0, 4'd2}, {4'd3, 4'd3, 4'd5});   // R3: enable W -> X
    chk("R3", int'(drv_out[3:0]), 1);
    apply({4'd0, 4'd0, 4'd2}, {4'd3, 4'd3, 4'd12});  // R10: enable code 12 -> X
    chk("R10", int'(drv_out[3:0]), 1);
    apply({4'd0, 4'd0, 4'd15}, {4'd3, 4'd3, 4'd2});  // R10: data code 15 -> X
    chk("R10", int'(drv_out[3:0]), 1);

    // Swap invariance (R9)
    for (int t = 0; t < 600; t++) begin
      logic [ND*4-1:0] d, e, d2, e2;
      for (int k = 0; k < ND; k++) begin
        d[k*4 +: 4] = 4'($urandom_range(0, 15));
        e[k*4 +: 4] = 4'($urandom_range(0, 15));
      end
      apply(d, e);
      check_all("R6");
      swap_bus = bus_val;
      d2 = {d[3:0], d[7:4], d[11:8]};
      e2 = {e[3:0], e[7:4], e[11:8]};
      apply(d2, e2);
      chk("R9", int'(bus_val), int'(swap_bus));
      d2 = {d[11:8], d[3:0], d[7:4]};
      e2 = {e[11:8], e[3:0], e[7:4]};
      apply(d2, e2);
      chk("R9", int'(bus_val), int'(swap_bus));
    end

    // Random legal codes, biased toward active drivers (R5 R6 R7 R8)
    for (int t = 0; t < 20000; t++) begin
      logic [ND*4-1:0] d, e;
      for (int k = 0; k < ND; k++) begin
        d[k*4 +: 4] = 4'($urandom_range(0, 8));
        e[k*4 +: 4] = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 8))
                                                  : (($urandom_range(0, 1) == 0) ? 4'd2 : 4'd7);
      end
      apply(d, e);
      check_all("R6");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule